// File: doc/BRIEF.md
# Serial Register Write Slave

This block receives 32-bit write frames from a host over a three-wire serial link (serial clock, active-high enable, serial data) and updates a bank of configuration registers. A frame begins when the enable rises. The first rising serial-clock edge samples a read/write flag. The next six edges take in a register address and the following twenty-four edges take in a data word, both most significant bit first. The write commits on the thirty-second rising edge.

The register bank and the update logic run in the system clock domain. A commit in the serial domain flips a toggle, and a two-flop synchronizer carries that toggle into the system domain. There it writes the addressed register and raises a one-cycle strobe with the address and data. The whole bank is exposed as a flat vector for the surrounding logic.

A frame is dropped without effect in three cases:
- The flag is high, which marks a read.
- The enable falls before the thirty-second edge.
- The frame is complete and further edges arrive while the enable stays high. These extra edges do nothing.

Top module: `regwr_serial_slave`

## Requirements
- R1: After reset every register reads zero and `wr_stb` is low.
- R2: A frame with flag 0 on edge 1, address bits on edges 2..7 and data bits on edges 8..31 (both MSB first) writes that data into that register, committed on edge 32. Register n occupies `regs_o[n*24 +: 24]`.
- R3: Each committed frame produces exactly one `wr_stb` pulse, one system-clock cycle long. While the pulse is high, `wr_addr` and `wr_data` carry the frame's address and data.
- R4: A frame whose flag on edge 1 is 1 (a read) writes no register and produces no strobe.
- R5: If the enable falls before edge 32, no register is written and no strobe is produced. The next frame is counted from edge 1 again.
- R6: Rising edges after edge 32 while the enable stays high are ignored. The register keeps the frame's data and no second strobe appears.
- R7: A write changes only the addressed register. Registers do not change in cycles where `wr_stb` is low. Addresses 0 and 63 are both reachable.
- R8: Frames sent back to back are all committed, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data sampled on rising edges |
| sen | input | 1 | Frame enable, active high |
| sdi | input | 1 | Serial data in |
| wr_stb | output | 1 | One-cycle write strobe in the system domain |
| wr_addr | output | 6 | Address of the latest write |
| wr_data | output | 24 | Data of the latest write |
| regs_o | output | 1536 | Flattened register bank, register n at [n*24 +: 24] |

## Verification
The hardest situation to reach is a frame that ends at exactly the wrong moment. One case is an enable that drops after edge 31 but before edge 32. The other is a run of extra edges after the commit, carrying data that differs from the frame. The bench's frame task therefore takes an explicit edge count. It can stop one edge short, or continue for eight extra edges driven with random data. The bench then checks that the register and the strobe count stay as the requirements say. A clean frame follows the aborted one, to show that the counter restarted.

// File: rtl/regwr_serial_slave.sv
module regwr_serial_slave #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 24,
  parameter int NUM_REGS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       sen,
  input  logic                       sdi,
  output logic                       wr_stb,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int FRAME = ADDR_W + DATA_W + 2;
  localparam int SH_W  = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [CNT_W-1:0]  cnt;
  logic              rd;
  logic [SH_W-1:0]   sh;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              tgl;
  logic              s1, s2, s3;
  logic [DATA_W-1:0] regs [NUM_REGS];

  wire frm_rst_n = rst_n & sen;
  wire fire      = s2 ^ s3;

  always_ff @(posedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) begin
      cnt <= '0;
      rd  <= 1'b0;
      sh  <= '0;
    end else if (cnt != CNT_W'(FRAME)) begin
      cnt <= cnt + 1'b1;
      if (cnt == '0)
        rd <= sdi;
      else if (cnt < CNT_W'(FRAME - 1))
        sh <= {sh[SH_W-2:0], sdi};
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr <= '0;
      hold_data <= '0;
      tgl       <= 1'b0;
    end else if (cnt == CNT_W'(FRAME - 1) && !rd) begin
      hold_addr <= sh[SH_W-1 -: ADDR_W];
      hold_data <= sh[DATA_W-1:0];
      tgl       <= ~tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tgl;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      wr_stb <= fire;
      if (fire) begin
        wr_addr <= hold_addr;
        wr_data <= hold_data;
        if (int'(hold_addr) < NUM_REGS) regs[hold_addr] <= hold_data;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[g*DATA_W +: DATA_W] = regs[g];
  end
endmodule

module regwr_serial_slave_chk #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 24,
  parameter int NUM_REGS = 64,
  parameter int CNT_W    = 6,
  parameter int FRAME    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sclk,
  input logic                       wr_stb,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input logic [CNT_W-1:0]           cnt,
  input logic                       rd,
  input logic                       tgl,
  input logic [ADDR_W-1:0]          hold_addr,
  input logic [DATA_W-1:0]          hold_data
);
  assert_stb_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_stb_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> regs_o[wr_addr*DATA_W +: DATA_W] == wr_data);

  assert_regs_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(regs_o));

  assert_read_nowrite_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    (rd && cnt != '0) |=> $stable(tgl));

  assert_after_frame_R6: assert property (@(posedge sclk) disable iff (!rst_n)
    (cnt == CNT_W'(FRAME)) |=> ($stable(hold_addr) && $stable(hold_data) && $stable(tgl)));
endmodule

bind regwr_serial_slave regwr_serial_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .FRAME(FRAME)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .regs_o(regs_o), .cnt(cnt), .rd(rd), .tgl(tgl),
  .hold_addr(hold_addr), .hold_data(hold_data)
);

// File: tb/regwr_serial_slave_bench.sv
`timescale 1ns/1ps
module regwr_serial_slave_bench;
  logic clk = 0, rst_n = 0, sclk = 0, sen = 0, sdi = 0;
  logic        wr_stb;
  logic [5:0]  wr_addr;
  logic [23:0] wr_data;
  logic [64*24-1:0] regs_o;

  int checks = 0, errors = 0, stb_cnt = 0;
  logic [5:0]  last_addr;
  logic [23:0] last_data;
  bit done = 0;

  regwr_serial_slave u_regwr_serial_slave (.*);

  always #10 clk = ~clk;

  always @(negedge clk) if (wr_stb) begin
    stb_cnt++;
    last_addr = wr_addr;
    last_data = wr_data;
  end

  function automatic logic [23:0] rget(int a);
    return regs_o[a*24 +: 24];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic frame(bit flag, logic [5:0] a, logic [23:0] d, int edges);
    logic [31:0] f = {flag, a, d, 1'b0};
    sen = 1;
    #10;
    for (int i = 0; i < edges; i++) begin
      sdi = (i < 32) ? f[31-i] : 1'($urandom);
      #10 sclk = 1;
      #10 sclk = 0;
    end
    #5 sen = 0;
    #10;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    logic any = 0;
    for (int i = 0; i < 64; i++) if (rget(i) != 0) any = 1;
    chk("R1 regs zero", any, 0);
    chk("R1 strobe low", wr_stb, 0);
  endtask

  task automatic t_write();
    int s0 = stb_cnt;
    frame(0, 6'd5, 24'hA5C3F1, 32);
    settle();
    chk("R2 reg5", rget(5), 24'hA5C3F1);
    chk("R3 strobe count", stb_cnt - s0, 1);
    chk("R3 strobe addr", last_addr, 5);
    chk("R3 strobe data", last_data, 24'hA5C3F1);
  endtask

  task automatic t_edges();
    frame(0, 6'd0, 24'hFFFFFF, 32);
    settle();
    frame(0, 6'd63, 24'h000001, 32);
    settle();
    chk("R7 reg0", rget(0), 24'hFFFFFF);
    chk("R7 reg63", rget(63), 24'h000001);
    chk("R7 reg5 untouched", rget(5), 24'hA5C3F1);
    chk("R7 reg1 untouched", rget(1), 0);
  endtask

  task automatic t_read();
    int s0 = stb_cnt;
    frame(1, 6'd5, 24'h123456, 32);
    settle();
    chk("R4 reg5 kept", rget(5), 24'hA5C3F1);
    chk("R4 no strobe", stb_cnt - s0, 0);
  endtask

  task automatic t_abort();
    int s0 = stb_cnt;
    frame(0, 6'd7, 24'h0BADF0, 31);
    settle();
    chk("R5 reg7 unwritten", rget(7), 0);
    chk("R5 no strobe", stb_cnt - s0, 0);
    frame(0, 6'd7, 24'h654321, 32);
    settle();
    chk("R5 restart write", rget(7), 24'h654321);
  endtask

  task automatic t_extra();
    int s0 = stb_cnt;
    frame(0, 6'd9, 24'h3C3C3C, 40);
    settle();
    chk("R6 reg9", rget(9), 24'h3C3C3C);
    chk("R6 one strobe", stb_cnt - s0, 1);
  endtask

  task automatic t_b2b();
    int s0 = stb_cnt;
    frame(0, 6'd20, 24'h111111, 32);
    frame(0, 6'd21, 24'h222222, 32);
    frame(0, 6'd20, 24'h333333, 32);
    settle();
    chk("R8 reg20 last", rget(20), 24'h333333);
    chk("R8 reg21", rget(21), 24'h222222);
    chk("R8 strobes", stb_cnt - s0, 3);
    chk("R8 last addr", last_addr, 20);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_write();
    t_edges();
    t_read();
    t_abort();
    t_extra();
    t_b2b();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule